// File: doc/BRIEF.md
# Cache Data ECC Enable and Fault Injection Controller

This block sits in front of a cache data RAM protected by single-error-correct, double-error-detect (SECDED) coding. A small control register turns check-bit generation on or off and lets software request deliberate corruption, so that the read-side correction and reporting logic elsewhere can be tested. Every RAM write passes through the block. It computes the check bits and registers the data word together with its check bits before they go to the RAM.

An injection request is armed by a 0-to-1 change of a request bit. The request then waits for the next RAM write, corrupts only that write, and clears itself. The register keeps the value software wrote. A single-bit request flips data bit 0 of the stored word, which a decoder can correct. A double-bit request flips data bits 0 and 1, which a decoder can detect but not correct. The check bits are always computed from the clean data.

The block has two resets. Cold reset clears everything. Warm reset leaves the register and any armed request in place and only flushes the output stage.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: Register layout: bit 0 is the ECC enable, bit 1 is the single-bit injection request and bit 2 is the double-bit injection request. All three are read/write and reset to 0. Bits 31 to 3 always read 0 and writes to them have no effect.
- R2: A synchronous cold reset clears the register, any armed injection and the output valid flag.
- R3: A warm reset keeps the register and any armed injection. While it is asserted, cw_valid stays 0 and RAM writes are dropped without using up an armed injection.
- R4: A write strobe on ram_we produces cw_valid high for exactly one cycle, on the clock edge that samples the strobe. cw_data and cw_check are valid in that same cycle.
- R5: With ECC enabled and no injection pending, cw_data equals the input data. The check bits are built as follows. Data bit k is placed at the (k+1)-th codeword position, counting from 1, whose position number is not a power of two. Check bit i is the XOR of the data bits whose position number has bit i set. The top check bit makes the whole codeword even parity. The Hamming syndrome of the output is then 0.
- R6: A register write that changes bit 1 from 0 to 1 arms a single injection. The next enabled RAM write has data bit 0 inverted (syndrome 3, overall parity odd). Later writes are clean.
- R7: A register write that changes bit 2 from 0 to 1 arms a double injection. The next enabled RAM write has data bits 0 and 1 inverted (syndrome 6, overall parity even). Later writes are clean.
- R8: Writing 1 to a request bit that already holds 1 arms nothing.
- R9: An armed injection waits through any number of idle cycles. An injection armed on the same edge as a RAM write applies to the following write, not to that one.
- R10: With ECC disabled, cw_check is all zero, cw_data equals the input data, and an armed injection is kept for the first write after ECC is enabled.
- R11: If both injections are armed at a write, only the double-bit corruption is applied and both armed requests clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous active-high cold reset |
| warm_rst | input | 1 | Synchronous active-high warm reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | REG_W | Control register write data |
| reg_rdata | output | REG_W | Control register read data |
| ram_we | input | 1 | RAM write strobe into the write path |
| ram_wdata | input | DATA_W | Clean data word to be written |
| cw_valid | output | 1 | Registered write strobe toward the RAM |
| cw_data | output | DATA_W | Registered data word, possibly corrupted |
| cw_check | output | chk_width(DATA_W) | Registered SECDED check bits |

## Verification
On every cycle the assertions check the following: the reserved bits read zero, cold reset clears the register and the armed requests, the register holds through warm reset, a write strobe produces a one-cycle output, data passes unmodified when nothing is armed, check bits are zero while ECC is disabled, and an armed request clears once an enabled write uses it or stays armed while ECC is disabled. Only the bench's scenarios can show that the check bits form a valid SECDED code, which bit positions the corruption hits, and that edge arming, same-edge timing and double-over-single priority produce the right syndrome on the right write.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

  typedef struct packed {
    logic inj_dbl;
    logic inj_sgl;
    logic ecc_on;
  } ctrl_t;

  localparam int CTRL_W = 3;

  // Number of Hamming parity bits needed to cover dw data bits.
  function automatic int hamming_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  // Hamming parity bits plus one overall parity bit.
  function automatic int chk_width(input int dw);
    return hamming_bits(dw) + 1;
  endfunction

endpackage

// File: rtl/ecc_ctrl_reg.sv
module ecc_ctrl_reg
  import ecc_inj_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             cold_rst,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output ctrl_t            ctrl_q,
  output logic             arm_sgl,
  output logic             arm_dbl
);
  localparam int PAD_W = REG_W - CTRL_W;

  ctrl_t wr_ctrl;
  assign wr_ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);

  // Only cold reset clears the register; warm reset is not wired in here.
  always_ff @(posedge clk) begin
    if (cold_rst)    ctrl_q <= '0;
    else if (reg_we) ctrl_q <= wr_ctrl;
  end

  // Arming fires only on a 0-to-1 change of a request bit.
  assign arm_sgl = reg_we && wr_ctrl.inj_sgl && !ctrl_q.inj_sgl;
  assign arm_dbl = reg_we && wr_ctrl.inj_dbl && !ctrl_q.inj_dbl;

  assign reg_rdata = {{PAD_W{1'b0}}, ctrl_q};
endmodule

// File: rtl/ecc_inj_pending.sv
module ecc_inj_pending (
  input  logic clk,
  input  logic cold_rst,
  input  logic arm_sgl,
  input  logic arm_dbl,
  input  logic consume,
  output logic pend_sgl,
  output logic pend_dbl
);
  // An arm on the same edge as a consume survives for the next write.
  always_ff @(posedge clk) begin
    if (cold_rst) begin
      pend_sgl <= 1'b0;
      pend_dbl <= 1'b0;
    end else begin
      pend_sgl <= (pend_sgl && !consume) || arm_sgl;
      pend_dbl <= (pend_dbl && !consume) || arm_dbl;
    end
  end
endmodule

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc
  import ecc_inj_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]                 data,
  output logic [chk_width(DATA_W)-1:0]      chk
);
  localparam int P      = hamming_bits(DATA_W);
  localparam int CW_LEN = DATA_W + P;

  always_comb begin
    int di;
    di  = 0;
    chk = '0;
    for (int pos = 1; pos <= CW_LEN; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int i = 0; i < P; i++) begin
          if (pos[i]) chk[i] = chk[i] ^ data[di];
        end
        di = di + 1;
      end
    end
    chk[P] = ^{data, chk[P-1:0]};
  end
endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl
  import ecc_inj_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 32
) (
  input  logic                          clk,
  input  logic                          cold_rst,
  input  logic                          warm_rst,
  input  logic                          reg_we,
  input  logic [REG_W-1:0]              reg_wdata,
  output logic [REG_W-1:0]              reg_rdata,
  input  logic                          ram_we,
  input  logic [DATA_W-1:0]             ram_wdata,
  output logic                          cw_valid,
  output logic [DATA_W-1:0]             cw_data,
  output logic [chk_width(DATA_W)-1:0]  cw_check
);
  localparam int CHK_W   = chk_width(DATA_W);
  localparam int SGL_BIT = 0;
  localparam int DBL_BIT = 1;

  ctrl_t              ctrl_q;
  logic               arm_sgl, arm_dbl;
  logic               pend_sgl, pend_dbl;
  logic               ecc_on;
  logic               wr_ok, consume;
  logic [DATA_W-1:0]  flip_mask;
  logic [CHK_W-1:0]   enc_chk;

  ecc_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk       (clk),
    .cold_rst  (cold_rst),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ctrl_q    (ctrl_q),
    .arm_sgl   (arm_sgl),
    .arm_dbl   (arm_dbl)
  );

  assign ecc_on  = ctrl_q.ecc_on;
  assign wr_ok   = ram_we && !cold_rst && !warm_rst;
  assign consume = wr_ok && ecc_on;

  ecc_inj_pending u_pend (
    .clk      (clk),
    .cold_rst (cold_rst),
    .arm_sgl  (arm_sgl),
    .arm_dbl  (arm_dbl),
    .consume  (consume),
    .pend_sgl (pend_sgl),
    .pend_dbl (pend_dbl)
  );

  ecc_secded_enc #(.DATA_W(DATA_W)) u_enc (
    .data (ram_wdata),
    .chk  (enc_chk)
  );

  // Double request wins over single; both clear on the consuming write.
  always_comb begin
    flip_mask = '0;
    if (ecc_on) begin
      if (pend_dbl) begin
        flip_mask[SGL_BIT] = 1'b1;
        flip_mask[DBL_BIT] = 1'b1;
      end else if (pend_sgl) begin
        flip_mask[SGL_BIT] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cold_rst || warm_rst) cw_valid <= 1'b0;
    else                      cw_valid <= ram_we;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      cw_data  <= ram_wdata ^ flip_mask;
      cw_check <= ecc_on ? enc_chk : '0;
    end
  end
endmodule

// File: rtl/ecc_inject_chk.sv
module ecc_inject_chk #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 32,
  parameter int CHK_W  = 7
) (
  input logic              clk,
  input logic              cold_rst,
  input logic              warm_rst,
  input logic              reg_we,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              ram_we,
  input logic [DATA_W-1:0] ram_wdata,
  input logic              cw_valid,
  input logic [DATA_W-1:0] cw_data,
  input logic [CHK_W-1:0]  cw_check,
  input logic              pend_sgl,
  input logic              pend_dbl
);
  logic arming;
  assign arming = reg_we && ((reg_wdata[1] && !reg_rdata[1]) ||
                             (reg_wdata[2] && !reg_rdata[2]));

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (cold_rst)
    reg_rdata[REG_W-1:3] == '0);

  // R2
  cold_clear_chk: assert property (@(posedge clk)
    cold_rst |=> (reg_rdata == '0 && !cw_valid && !pend_sgl && !pend_dbl));

  // R3
  warm_keep_chk: assert property (@(posedge clk) disable iff (cold_rst)
    (warm_rst && !reg_we) |=> ($stable(reg_rdata) && !cw_valid));

  // R4
  out_strobe_chk: assert property (@(posedge clk) disable iff (cold_rst)
    (ram_we && !warm_rst) |=> cw_valid);

  // R5
  clean_pass_chk: assert property (@(posedge clk) disable iff (cold_rst)
    (ram_we && !warm_rst && !pend_sgl && !pend_dbl) |=> cw_data == $past(ram_wdata));

  // R10
  off_zero_chk: assert property (@(posedge clk) disable iff (cold_rst)
    (ram_we && !warm_rst && !reg_rdata[0]) |=> (cw_check == '0 && cw_data == $past(ram_wdata)));

  // R10
  off_hold_chk: assert property (@(posedge clk) disable iff (cold_rst)
    (ram_we && !warm_rst && !reg_rdata[0] && pend_sgl) |=> pend_sgl);

  // R6 R7 R11
  one_shot_chk: assert property (@(posedge clk) disable iff (cold_rst)
    ((pend_sgl || pend_dbl) && ram_we && !warm_rst && reg_rdata[0] && !arming)
      |=> (!pend_sgl && !pend_dbl));
endmodule

bind ecc_inject_ctrl ecc_inject_chk #(
  .DATA_W(DATA_W), .REG_W(REG_W), .CHK_W(CHK_W)
) u_chk (
  .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
  .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .ram_we(ram_we), .ram_wdata(ram_wdata),
  .cw_valid(cw_valid), .cw_data(cw_data), .cw_check(cw_check),
  .pend_sgl(pend_sgl), .pend_dbl(pend_dbl)
);

// File: tb/ecc_inject_ctrl_bench.sv
module ecc_inject_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int RW = 32;
  localparam int P  = 6;
  localparam int CW = P + 1;

  localparam int K_CLEAN = 0;
  localparam int K_SGL   = 1;
  localparam int K_DBL   = 2;
  localparam int K_OFF   = 3;

  logic          clk = 1'b0;
  logic          cold_rst = 1'b1;
  logic          warm_rst = 1'b0;
  logic          reg_we = 1'b0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic          ram_we = 1'b0;
  logic [DW-1:0] ram_wdata = '0;
  logic          cw_valid;
  logic [DW-1:0] cw_data;
  logic [CW-1:0] cw_check;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_inject_ctrl #(.DATA_W(DW), .REG_W(RW)) u_ecc_inject_ctrl (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ram_we(ram_we), .ram_wdata(ram_wdata),
    .cw_valid(cw_valid), .cw_data(cw_data), .cw_check(cw_check)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Hamming syndrome and overall parity of (data, check), built from R5.
  function automatic int syndrome(input logic [DW-1:0] d, input logic [CW-1:0] c);
    int s = 0; int di = 0;
    for (int pos = 1; pos <= DW + P; pos++) begin
      logic b;
      b = 1'b0;
      if ((pos & (pos - 1)) == 0) begin
        for (int k = 0; k < P; k++) if (pos == (1 << k)) b = c[k];
      end else begin
        b = d[di]; di++;
      end
      if (b) s = s ^ pos;
    end
    return s;
  endfunction

  function automatic logic parity_all(input logic [DW-1:0] d, input logic [CW-1:0] c);
    return ^{d, c};
  endfunction

  task automatic reg_write(input logic [RW-1:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  // Issues one RAM write and checks the registered codeword a cycle later.
  task automatic ram_write(input logic [DW-1:0] d, input int kind, input string req);
    logic [DW-1:0] exp_d;
    int exp_s; logic exp_p;
    @(negedge clk); ram_we = 1'b1; ram_wdata = d;
    @(negedge clk); ram_we = 1'b0;
    exp_d = d; exp_s = 0; exp_p = 1'b0;
    if (kind == K_SGL) begin exp_d = d ^ 32'h1; exp_s = 3; exp_p = 1'b1; end
    if (kind == K_DBL) begin exp_d = d ^ 32'h3; exp_s = 6; exp_p = 1'b0; end
    check(cw_valid === 1'b1, {req, " valid"}, 64'(cw_valid), 64'd1);
    check(cw_data === exp_d, {req, " data"}, 64'(cw_data), 64'(exp_d));
    if (kind == K_OFF) begin
      check(cw_check === '0, {req, " check zero"}, 64'(cw_check), 64'd0);
    end else begin
      check(syndrome(cw_data, cw_check) == exp_s, {req, " syndrome"},
            64'(syndrome(cw_data, cw_check)), 64'(exp_s));
      check(parity_all(cw_data, cw_check) === exp_p, {req, " parity"},
            64'(parity_all(cw_data, cw_check)), 64'(exp_p));
    end
  endtask

  task automatic t_reset;
    check(reg_rdata === '0, "R2 reset reg", 64'(reg_rdata), 64'd0);
    check(cw_valid === 1'b0, "R2 reset valid", 64'(cw_valid), 64'd0);
  endtask

  task automatic t_layout;
    reg_write(32'hFFFF_FFF8);
    check(reg_rdata === '0, "R1 reserved", 64'(reg_rdata), 64'd0);
    reg_write(32'hFFFF_FFF9);
    check(reg_rdata === 32'h1, "R1 enable bit", 64'(reg_rdata), 64'd1);
  endtask

  task automatic t_clean;
    ram_write(32'hDEAD_BEEF, K_CLEAN, "R5 clean a");
    ram_write(32'h0000_0000, K_CLEAN, "R5 clean b");
    ram_write(32'h8000_0001, K_CLEAN, "R5 clean c");
    @(negedge clk);
    check(cw_valid === 1'b0, "R4 single pulse", 64'(cw_valid), 64'd0);
  endtask

  task automatic t_single;
    reg_write(32'h3);
    ram_write(32'h1234_5678, K_SGL, "R6 single");
    ram_write(32'h1234_5678, K_CLEAN, "R6 one shot");
  endtask

  task automatic t_rewrite;
    reg_write(32'h3);
    ram_write(32'hA5A5_A5A5, K_CLEAN, "R8 no rearm");
    reg_write(32'h1);
    reg_write(32'h3);
    repeat (5) @(negedge clk);
    ram_write(32'h0F0F_0F0F, K_SGL, "R9 held idle");
  endtask

  task automatic t_double;
    reg_write(32'h1);
    reg_write(32'h5);
    ram_write(32'hCAFE_F00D, K_DBL, "R7 double");
    ram_write(32'hCAFE_F00D, K_CLEAN, "R7 one shot");
  endtask

  task automatic t_both;
    reg_write(32'h1);
    reg_write(32'h7);
    ram_write(32'h5555_AAAA, K_DBL, "R11 priority");
    ram_write(32'h5555_AAAA, K_CLEAN, "R11 both clear");
  endtask

  task automatic t_disabled;
    reg_write(32'h0);
    reg_write(32'h2);
    ram_write(32'h1357_9BDF, K_OFF, "R10 disabled");
    reg_write(32'h3);
    ram_write(32'h1357_9BDF, K_SGL, "R10 held pending");
    ram_write(32'h1357_9BDF, K_CLEAN, "R10 then clean");
  endtask

  task automatic t_same_edge;
    reg_write(32'h1);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = 32'h3; ram_we = 1'b1; ram_wdata = 32'h2468_ACE0;
    @(negedge clk);
    reg_we = 1'b0; ram_we = 1'b0;
    check(cw_data === 32'h2468_ACE0, "R9 same edge clean", 64'(cw_data), 64'h2468_ACE0);
    check(syndrome(cw_data, cw_check) == 0, "R9 same edge syndrome",
          64'(syndrome(cw_data, cw_check)), 64'd0);
    ram_write(32'h2468_ACE0, K_SGL, "R9 next write");
  endtask

  task automatic t_warm;
    reg_write(32'h1);
    reg_write(32'h5);
    @(negedge clk);
    warm_rst = 1'b1; ram_we = 1'b1; ram_wdata = 32'h1111_2222;
    @(negedge clk);
    check(cw_valid === 1'b0, "R3 valid during warm", 64'(cw_valid), 64'd0);
    @(negedge clk);
    warm_rst = 1'b0; ram_we = 1'b0;
    @(negedge clk);
    check(reg_rdata === 32'h5, "R3 reg kept", 64'(reg_rdata), 64'd5);
    ram_write(32'h3333_4444, K_DBL, "R3 pending kept");
  endtask

  task automatic t_cold;
    reg_write(32'h3);
    @(negedge clk); cold_rst = 1'b1;
    @(negedge clk); cold_rst = 1'b0;
    check(reg_rdata === '0, "R2 cold clears reg", 64'(reg_rdata), 64'd0);
    check(cw_valid === 1'b0, "R2 cold clears valid", 64'(cw_valid), 64'd0);
    reg_write(32'h1);
    ram_write(32'h7777_8888, K_CLEAN, "R2 pending cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cold_rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_layout();
    t_clean();
    t_single();
    t_rewrite();
    t_double();
    t_both();
    t_disabled();
    t_same_edge();
    t_warm();
    t_cold();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule